// File: doc/BRIEF.md
# Multifunction ALU with Funnel Shifter

A purely combinational integer ALU of parameterised width (32 bits by default). A 2-bit group selector picks one of four result sources. The first is a shift/rotate unit. The second returns a signed less-than compare. The third is an adder/subtractor. The fourth is a bitwise logic unit. A 2-bit sub-operation field refines the choice inside the chosen group.

All four shift kinds run on one right-only logarithmic shifter. The operand is first widened to a `2*W-1` bit word, and the way it is widened decides whether zeros, sign copies or the operand's own low bits fill in behind the shift. A left shift reuses the same right shifter: the operand is placed at the top of the widened word and the shift amount is complemented bitwise. A rotate-left has no encoding of its own; software issues a rotate-right by `W - k`.

The signed compare runs a subtraction and takes the sign of the difference XOR the subtraction's overflow. The compare is therefore correct even when the difference wraps.

Top module: `mfalu`

## Requirements
- R1: `grp_sel` selects the result source. The code 00 gives shift/rotate, 01 gives signed less-than, 10 gives add/subtract and 11 gives bitwise logic.
- R2: In the logic group, `sub_op` selects the bitwise function. The code 00 gives AND, 01 gives OR, 10 gives NOR and 11 gives XOR of `opnd_a` and `opnd_b`.
- R3: In the arithmetic group, `sub_op[0]` = 0 gives `opnd_a + opnd_b` and 1 gives `opnd_a - opnd_b`, both modulo 2^W. `sub_op[1]` has no effect.
- R4: `ovf_flag` is 1 exactly when the arithmetic group's signed two's-complement result overflows, in either direction. It is 0 whenever `grp_sel` is not 10.
- R5: In the less-than group, `result` is 1 when `opnd_a < opnd_b` as signed numbers and 0 otherwise. Bits W-1..1 are always 0. The compare is correct when the difference overflows.
- R6: Shift `sub_op` 10 is a logical right shift of `opnd_a` by `shamt` (0..W-1), filling with zeros.
- R7: Shift `sub_op` 01 is an arithmetic right shift of `opnd_a` by `shamt`, filling with copies of bit W-1.
- R8: Shift `sub_op` 11 rotates `opnd_a` right by `shamt`. Bits leaving bit 0 re-enter at bit W-1.
- R9: Shift `sub_op` 00 is a logical left shift of `opnd_a` by `shamt`, filling with zeros. An amount of 0 returns `opnd_a` unchanged and an amount of W-1 leaves only bit 0 of `opnd_a`, moved to bit W-1.
- R10: `zero_flag` is 1 exactly when the selected W-bit `result` is all zeros, in every group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; also the data that is shifted |
| opnd_b | input | 32 | Second operand |
| shamt | input | 5 | Shift or rotate amount |
| grp_sel | input | 2 | Result group selector |
| sub_op | input | 2 | Operation within the group |
| result | output | 32 | Selected result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add/subtract |

## Verification
All sixteen selector and sub-operation codes are applied to a grid of edge operands: zero, one, the largest positive value, the most negative value, all ones and a mixed pattern. Each is combined with shift amounts 0, 1, 16 and 31. This grid separates zero fill from sign fill from wrap-around fill at both ends of the amount range. It also hits positive and negative add/subtract overflow, and the compare cases where the difference wraps. Random operands, amounts and codes then exercise the interior. Each result is compared with the plain language operators (`>>`, `>>>`, `<<`, a doubled-word rotate, signed `<`, wide-integer range tests). This shows that the widened-word construction and the complemented left-shift amount agree with the plain shifts and compares.

// File: rtl/mfalu_pkg.sv
// Shared encodings for the multifunction ALU.
// Assumes: every encoding is 2 bits wide and used by the top and its sub-units alike.
package mfalu_pkg;
    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_SLT   = 2'b01,
        GRP_ARITH = 2'b10,
        GRP_LOGIC = 2'b11
    } grp_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_NOR = 2'b10,
        LG_XOR = 2'b11
    } lg_e;

    typedef enum logic [1:0] {
        SH_SLL = 2'b00,
        SH_SRA = 2'b01,
        SH_SRL = 2'b10,
        SH_ROR = 2'b11
    } sh_e;
endpackage

// File: rtl/mfalu_logic.sv
// Bitwise logic unit: AND, OR, NOR or XOR of two words.
// Assumes: the op code follows mfalu_pkg::lg_e; purely combinational.
module mfalu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] y
);
    import mfalu_pkg::*;

    // Select the bitwise function.
    always_comb begin
        case (op)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_NOR:  y = ~(a | b);
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/mfalu_addsub.sv
// Adder/subtractor with signed overflow detection.
// Assumes: subtraction is a + ~b + 1, so the carry-in is the sub control.
module mfalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    // Invert B for subtraction, add with carry-in, then flag sign overflow.
    always_comb begin
        b_eff = b ^ {W{sub}};
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/mfalu_funnel.sv
// Funnel shifter: one logarithmic right shifter over a 2W-1 bit word
// serves logical/arithmetic right shift, rotate right and left shift.
// Assumes: W is a power of two; the mode code follows mfalu_pkg::sh_e.
module mfalu_funnel #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic [1:0]    mode,
    output logic [W-1:0]  dout
);
    import mfalu_pkg::*;

    localparam int EW = 2 * W - 1;

    logic [EW-1:0] ext;
    logic [SW-1:0] eff_amt;
    logic [EW-1:0] stg [0:SW];

    // Build the widened word and the effective right-shift amount.
    always_comb begin
        case (mode)
            SH_SLL:  ext = {din, {(W-1){1'b0}}};
            SH_SRA:  ext = {{(W-1){din[W-1]}}, din};
            SH_SRL:  ext = {{(W-1){1'b0}}, din};
            default: ext = {din[W-2:0], din};
        endcase
        eff_amt = (mode == SH_SLL) ? ~amt : amt;
    end

    assign stg[0] = ext;

    // One mux stage per amount bit, shifting right by 2**k.
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stg[k+1] = eff_amt[k] ? (stg[k] >> DIST) : stg[k];
    end

    assign dout = stg[SW][W-1:0];
endmodule

// File: rtl/mfalu.sv
// Multifunction ALU top: picks shift, signed less-than, add/subtract or
// logic result by group code, and produces zero and overflow flags.
// Assumes: purely combinational; the caller registers inputs and outputs.
module mfalu #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [SW-1:0] shamt,
    input  logic [1:0]    grp_sel,
    input  logic [1:0]    sub_op,
    output logic [W-1:0]  result,
    output logic          zero_flag,
    output logic          ovf_flag
);
    import mfalu_pkg::*;

    logic [W-1:0] sh_y, lg_y, as_sum;
    logic         as_ovf, do_sub;

    // The compare group always subtracts; the arithmetic group follows sub_op[0].
    assign do_sub = (grp_sel == GRP_SLT) || ((grp_sel == GRP_ARITH) && sub_op[0]);

    mfalu_funnel #(.W(W), .SW(SW)) u_shift (
        .din(opnd_a), .amt(shamt), .mode(sub_op), .dout(sh_y)
    );

    mfalu_logic #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b), .op(sub_op), .y(lg_y)
    );

    mfalu_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(do_sub), .sum(as_sum), .ovf(as_ovf)
    );

    // Final result mux and flags.
    always_comb begin
        case (grp_sel)
            GRP_SHIFT: result = sh_y;
            GRP_SLT:   result = {{(W-1){1'b0}}, as_sum[W-1] ^ as_ovf};
            GRP_ARITH: result = as_sum;
            default:   result = lg_y;
        endcase
        zero_flag = (result == '0);
        ovf_flag  = (grp_sel == GRP_ARITH) && as_ovf;
    end
endmodule

// File: rtl/mfalu_chk.sv
// Checker for the ALU: immediate assertions on settled combinational values.
// Assumes: inputs are stable between evaluations; bound into every mfalu.
module mfalu_chk #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input logic [W-1:0]  opnd_a,
    input logic [W-1:0]  opnd_b,
    input logic [SW-1:0] shamt,
    input logic [1:0]    grp_sel,
    input logic [1:0]    sub_op,
    input logic [W-1:0]  result,
    input logic          ovf_flag
);
    // Check group-level invariants whenever anything changes.
    always_comb begin
        if (grp_sel != 2'b10)
            assert_no_overflow_R4: assert (!ovf_flag);
        if (grp_sel == 2'b01)
            assert_slt_upper_zero_R5: assert (result[W-1:1] == '0);
        if (grp_sel == 2'b10 && opnd_b == '0)
            assert_add_identity_R3: assert (result == opnd_a);
        if (grp_sel == 2'b00 && sub_op == 2'b10 && shamt == '0)
            assert_srl_identity_R6: assert (result == opnd_a);
        if (grp_sel == 2'b00 && sub_op == 2'b00 && shamt == '0)
            assert_sll_identity_R9: assert (result == opnd_a);
        if (grp_sel == 2'b00 && sub_op == 2'b11 && shamt == '0)
            assert_ror_identity_R8: assert (result == opnd_a);
    end
endmodule

bind mfalu mfalu_chk #(.W(W), .SW(SW)) u_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .grp_sel(grp_sel),
    .sub_op(sub_op), .result(result), .ovf_flag(ovf_flag)
);

// File: tb/mfalu_test.sv
// Self-checking bench: directed corner grid plus seeded random vectors.
module mfalu_test;
    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  grp_sel = '0, sub_op = '0;
    logic [31:0] result;
    logic        zero_flag, ovf_flag;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mfalu uut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .grp_sel(grp_sel),
        .sub_op(sub_op), .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
    );

    function automatic logic [31:0] exp_res(logic [1:0] g, logic [1:0] s,
                                           logic [31:0] a, logic [31:0] b, logic [4:0] k);
        logic [63:0] dbl;
        dbl = {a, a} >> k;
        case (g)
            2'b00: case (s)
                2'b00: return a << k;
                2'b01: return $signed(a) >>> k;
                2'b10: return a >> k;
                default: return dbl[31:0];
            endcase
            2'b01: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            2'b10: return s[0] ? a - b : a + b;
            default: case (s)
                2'b00: return a & b;
                2'b01: return a | b;
                2'b10: return ~(a | b);
                default: return a ^ b;
            endcase
        endcase
    endfunction

    function automatic logic exp_ovf(logic [1:0] g, logic [1:0] s,
                                     logic [31:0] a, logic [31:0] b);
        longint r;
        if (g != 2'b10) return 1'b0;
        r = s[0] ? longint'($signed(a)) - longint'($signed(b))
                 : longint'($signed(a)) + longint'($signed(b));
        return (r > 64'sd2147483647) || (r < -64'sd2147483648);
    endfunction

    function automatic string tag_of(logic [1:0] g, logic [1:0] s);
        case (g)
            2'b00: case (s)
                2'b00: return "R9 sll";
                2'b01: return "R7 sra";
                2'b10: return "R6 srl";
                default: return "R8 ror";
            endcase
            2'b01: return "R5 slt";
            2'b10: return "R3 addsub";
            default: return "R2 logic";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h k=%0d g=%b s=%b)",
                     tag, act, exp, opnd_a, opnd_b, shamt, grp_sel, sub_op);
        end
    endtask

    task automatic apply(logic [1:0] g, logic [1:0] s, logic [31:0] a,
                         logic [31:0] b, logic [4:0] k);
        logic [31:0] e;
        @(negedge clk);
        grp_sel = g; sub_op = s; opnd_a = a; opnd_b = b; shamt = k;
        #1;
        e = exp_res(g, s, a, b, k);
        // R1: group code picks the source named by tag_of
        check({"R1/", tag_of(g, s)}, result, e);
        check("R4 overflow", {31'd0, ovf_flag}, {31'd0, exp_ovf(g, s, a, b)});
        check("R10 zero", {31'd0, zero_flag}, {31'd0, (e == 32'd0)});
    endtask

    initial begin
        logic [31:0] vals [6];
        logic [4:0]  amts [4];
        vals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
        amts = '{5'd0, 5'd1, 5'd16, 5'd31};
        void'($urandom(32'd20240611));

        // Idle state: all-zero inputs give a zero result and flags (R10)
        #1;
        check("R10 idle result", result, 32'd0);
        check("R10 idle zero", {31'd0, zero_flag}, 32'd1);
        check("R4 idle ovf", {31'd0, ovf_flag}, 32'd0);

        // Directed overflow in both directions (R4) and wrapped compare (R5)
        apply(2'b10, 2'b00, 32'h7FFF_FFFF, 32'h1, 5'd0);
        apply(2'b10, 2'b01, 32'h8000_0000, 32'h1, 5'd0);
        apply(2'b01, 2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
        apply(2'b01, 2'b00, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
        // R3: sub_op[1] ignored in the arithmetic group
        apply(2'b10, 2'b11, 32'h0000_0005, 32'h0000_0007, 5'd0);
        // R9: left shift by W-1 keeps only bit 0 at the top
        apply(2'b00, 2'b00, 32'hFFFF_FFFF, 32'h0, 5'd31);

        // Corner grid over every code
        for (int g = 0; g < 4; g++)
            for (int s = 0; s < 4; s++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        for (int m = 0; m < 4; m++)
                            apply(2'(g), 2'(s), vals[i], vals[j], amts[m]);

        // Random interior
        for (int n = 0; n < 3000; n++)
            apply(2'($urandom), 2'($urandom), $urandom, $urandom, 5'($urandom));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule